// File: doc/BRIEF.md
# Command Queue Transfer Sequencer

The sequencer walks a small local queue of conversion command words. A transfer counter serves as the read index. Each command goes to one of two downstream command buffers, and each buffer has its own valid/ready handshake. Every command word carries control bits that shape the walk:

- **End-of-queue** closes a scan.
- **Pause** ends a sub-queue and parks the queue until the next trigger.
- **Repeat-start** marks where a streaming loop begins again.

The queue is loaded through a simple write port and enabled by a mode selection. An arm pulse starts it from idle. In the two edge-triggered modes, a rising edge on the trigger input starts or resumes the transfer. In the software mode, transfers start at once and pause has no effect on status. The queue status, the transfer counter, and three sticky flags are visible at the ports: end-of-queue seen, pause seen, and reserved command seen.

The block reads command words in place and forwards them whole. The calibrate bit and the payload reach the buffer unchanged. It does not convert, calibrate, or drive any external buffer.

Top module: `cmdq_seq`

## Requirements
- R1: After reset the status is idle (0), the counter is 0, neither buffer valid is high and all three sticky flags are clear.
- R2: Mode encoding on `mode_i`: 0 off, 1 single-scan edge, 2 continuous-scan edge, 3 software start. Status encoding: 0 idle, 1 waiting-for-trigger, 2 transferring. An `arm_i` pulse in idle with the counter cleared moves to status 1 in modes 1 and 2, and to status 2 in mode 3.
- R3: In status 1, a rising edge of `trig_i` moves the status to 2. Trigger edges in idle or while transferring, and a trigger held high, have no effect.
- R4: While transferring, command bit 6 selects the destination: 0 raises only `buf0_valid_o`, 1 raises only `buf1_valid_o`. The data output carries the full command word unchanged, including calibrate bit 7.
- R5: A transfer completes only in a cycle where the selected buffer's ready is high. Until then valid stays up and the counter holds. Each completed transfer advances the counter by one.
- R6: Command bit 1 (pause) sets the pause flag when its transfer completes. In modes 1 and 2 the status then becomes 1. In mode 3 the transfer continues.
- R7: Command bit 0 (end-of-queue) sets the end-of-queue flag and clears the counter when its transfer completes. The status then becomes 0 in modes 1 and 3, and 1 in mode 2.
- R8: A command with both bits 0 and 1 set raises both flags, and the status follows R7 alone.
- R9: When `stream_i` is high in modes 1 and 2, a command with bit 2 (repeat-start) records its index. At the trigger edge that follows a completed pause, the counter is loaded with that index.
- R10: If several repeat-start commands precede a pause, only the first one's index is kept.
- R11: A command with bit 5 set is reserved. It raises no valid, sets the error flag, completes in one cycle without ready, and still advances the counter. Its pause and end-of-queue bits are still acted on.
- R12: The flags stay set until a `flag_clr_i` cycle clears them all. A flag set in that same cycle wins over the clear.
- R13: Mode 0 returns the status to 0 and the counter to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_we_i | input | 1 | Queue write enable |
| load_addr_i | input | IDX_W | Queue write index |
| load_data_i | input | CMD_W | Command word to store |
| mode_i | input | 2 | Trigger mode (R2 encoding) |
| arm_i | input | 1 | Start the queue from idle |
| stream_i | input | 1 | Enable repeat-start looping |
| trig_i | input | 1 | Trigger, rising edge active |
| flag_clr_i | input | 1 | Clear all sticky flags |
| buf0_valid_o | output | 1 | Command offered to buffer 0 |
| buf0_ready_i | input | 1 | Buffer 0 accepts |
| buf0_data_o | output | CMD_W | Command word to buffer 0 |
| buf1_valid_o | output | 1 | Command offered to buffer 1 |
| buf1_ready_i | input | 1 | Buffer 1 accepts |
| buf1_data_o | output | CMD_W | Command word to buffer 1 |
| status_o | output | 2 | Queue status (R2 encoding) |
| tc_o | output | IDX_W | Transfer counter |
| eoq_flag_o | output | 1 | Sticky end-of-queue flag |
| pause_flag_o | output | 1 | Sticky pause flag |
| err_flag_o | output | 1 | Sticky reserved-command flag |

## Verification
The bench runs the queue under each trigger mode with different arrangements of the control bits:

- A plain single scan with a mid-queue pause shows that sub-queue parking differs from end-of-scan.
- A combined pause-and-end command in continuous mode separates the flag rule from the status rule.
- A software-mode run containing a reserved command shows that pause is ignored there and that dropped commands still advance.
- A streaming queue with two repeat-start commands shows which index is reloaded.

Buffer readiness follows an irregular pattern, and one run holds it low, so stalls are tested apart from completions. A trigger held high or pulsed while idle shows that only edges in the waiting state count.

// File: rtl/cmdq_seq_pkg.sv
package cmdq_seq_pkg;
  typedef enum logic [1:0] {Q_IDLE = 2'd0, Q_WAIT = 2'd1, Q_XFER = 2'd2} q_stat_e;
  typedef enum logic [1:0] {M_OFF = 2'd0, M_SINGLE = 2'd1, M_CONT = 2'd2, M_SOFT = 2'd3} q_mode_e;

  localparam int unsigned B_EOQ   = 0;
  localparam int unsigned B_PAUSE = 1;
  localparam int unsigned B_REP   = 2;
  localparam int unsigned B_EXT   = 5;
  localparam int unsigned B_SEL   = 6;
  localparam int unsigned B_CAL   = 7;

  typedef struct packed {
    logic cal;
    logic sel;
    logic ext;
    logic rep;
    logic pause;
    logic eoq;
  } cmd_ctl_t;
endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] waddr_i,
  input  logic [CMD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0] raddr_i,
  output logic [CMD_W-1:0] rdata_o
);
  logic [CMD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cmdq_decode.sv
module cmdq_decode
  import cmdq_seq_pkg::*;
#(
  parameter int unsigned CMD_W = 32
) (
  input  logic [CMD_W-1:0] cmd_i,
  output cmd_ctl_t         ctl_o
);
  always_comb begin
    ctl_o.eoq   = cmd_i[B_EOQ];
    ctl_o.pause = cmd_i[B_PAUSE];
    ctl_o.rep   = cmd_i[B_REP];
    ctl_o.ext   = cmd_i[B_EXT];
    ctl_o.sel   = cmd_i[B_SEL];
    ctl_o.cal   = cmd_i[B_CAL];
  end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl
  import cmdq_seq_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  q_mode_e          mode_i,
  input  logic             arm_i,
  input  logic             stream_i,
  input  logic             trig_edge_i,
  input  cmd_ctl_t         ctl_i,
  input  logic             acc_i,
  output q_stat_e          state_o,
  output logic [IDX_W-1:0] tc_o,
  output logic             done_o
);
  q_stat_e          state_q;
  logic [IDX_W-1:0] tc_q, rep_idx_q;
  logic             rep_vld_q, reload_q;
  logic             edge_mode;

  assign edge_mode = (mode_i == M_SINGLE) || (mode_i == M_CONT);
  // reserved commands are consumed without a handshake
  assign done_o    = (state_q == Q_XFER) && (ctl_i.ext || acc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= Q_IDLE;
      tc_q      <= '0;
      rep_idx_q <= '0;
      rep_vld_q <= 1'b0;
      reload_q  <= 1'b0;
    end else if (mode_i == M_OFF) begin
      state_q   <= Q_IDLE;
      tc_q      <= '0;
      rep_vld_q <= 1'b0;
      reload_q  <= 1'b0;
    end else begin
      unique case (state_q)
        Q_IDLE: if (arm_i) begin
          tc_q      <= '0;
          rep_vld_q <= 1'b0;
          reload_q  <= 1'b0;
          state_q   <= (mode_i == M_SOFT) ? Q_XFER : Q_WAIT;
        end
        Q_WAIT: if (trig_edge_i) begin
          state_q <= Q_XFER;
          if (reload_q) begin
            tc_q     <= rep_idx_q;
            reload_q <= 1'b0;
          end
        end
        Q_XFER: if (done_o) begin
          if (ctl_i.rep && !rep_vld_q) begin
            rep_vld_q <= 1'b1;
            rep_idx_q <= tc_q;
          end
          if (ctl_i.eoq) begin
            tc_q      <= '0;
            rep_vld_q <= 1'b0;
            reload_q  <= 1'b0;
            state_q   <= (mode_i == M_CONT) ? Q_WAIT : Q_IDLE;
          end else begin
            tc_q <= tc_q + 1'b1;
            if (ctl_i.pause && edge_mode) begin
              reload_q  <= stream_i && (rep_vld_q || ctl_i.rep);
              rep_vld_q <= 1'b0;
              state_q   <= Q_WAIT;
            end
          end
        end
        default: state_q <= Q_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign tc_o    = tc_q;
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_seq_pkg::*;
#(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_we_i,
  input  logic [IDX_W-1:0] load_addr_i,
  input  logic [CMD_W-1:0] load_data_i,
  input  logic [1:0]       mode_i,
  input  logic             arm_i,
  input  logic             stream_i,
  input  logic             trig_i,
  input  logic             flag_clr_i,
  output logic             buf0_valid_o,
  input  logic             buf0_ready_i,
  output logic [CMD_W-1:0] buf0_data_o,
  output logic             buf1_valid_o,
  input  logic             buf1_ready_i,
  output logic [CMD_W-1:0] buf1_data_o,
  output logic [1:0]       status_o,
  output logic [IDX_W-1:0] tc_o,
  output logic             eoq_flag_o,
  output logic             pause_flag_o,
  output logic             err_flag_o
);
  logic [CMD_W-1:0] cmd;
  cmd_ctl_t         ctl;
  q_stat_e          state;
  logic [IDX_W-1:0] tc;
  logic             trig_q, trig_edge, done, acc, xfer;
  logic             eoq_q, pause_q, err_q;

  cmdq_store #(.CMD_W(CMD_W), .DEPTH(DEPTH)) u_store (
    .clk_i   (clk_i),
    .we_i    (load_we_i),
    .waddr_i (load_addr_i),
    .wdata_i (load_data_i),
    .raddr_i (tc),
    .rdata_o (cmd)
  );

  cmdq_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_i (cmd),
    .ctl_o (ctl)
  );

  cmdq_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (q_mode_e'(mode_i)),
    .arm_i       (arm_i),
    .stream_i    (stream_i),
    .trig_edge_i (trig_edge),
    .ctl_i       (ctl),
    .acc_i       (acc),
    .state_o     (state),
    .tc_o        (tc),
    .done_o      (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_q <= 1'b0;
    else         trig_q <= trig_i;
  end
  assign trig_edge = trig_i && !trig_q;

  assign xfer = (state == Q_XFER);
  assign acc  = ctl.sel ? buf1_ready_i : buf0_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoq_q   <= 1'b0;
      pause_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (flag_clr_i) begin
        eoq_q   <= 1'b0;
        pause_q <= 1'b0;
        err_q   <= 1'b0;
      end
      // set beats clear
      if (done && ctl.eoq)   eoq_q   <= 1'b1;
      if (done && ctl.pause) pause_q <= 1'b1;
      if (done && ctl.ext)   err_q   <= 1'b1;
    end
  end

  assign buf0_valid_o = xfer && !ctl.ext && !ctl.sel;
  assign buf1_valid_o = xfer && !ctl.ext && ctl.sel;
  assign buf0_data_o  = cmd;
  assign buf1_data_o  = cmd;
  assign status_o     = state;
  assign tc_o         = tc;
  assign eoq_flag_o   = eoq_q;
  assign pause_flag_o = pause_q;
  assign err_flag_o   = err_q;
endmodule

// File: rtl/cmdq_seq_chk.sv
module cmdq_seq_chk #(
  parameter int unsigned CMD_W = 32,
  parameter int unsigned IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       mode_i,
  input logic             flag_clr_i,
  input logic             buf0_valid_o,
  input logic             buf0_ready_i,
  input logic [CMD_W-1:0] buf0_data_o,
  input logic             buf1_valid_o,
  input logic             buf1_ready_i,
  input logic [CMD_W-1:0] buf1_data_o,
  input logic [1:0]       status_o,
  input logic [IDX_W-1:0] tc_o,
  input logic             eoq_flag_o,
  input logic             err_flag_o
);
  // R4
  one_dest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(buf0_valid_o && buf1_valid_o));

  // R4
  route0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf0_valid_o |-> !buf0_data_o[6]);

  // R4
  route1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf1_valid_o |-> buf1_data_o[6]);

  // R5
  stall0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf0_valid_o && !buf0_ready_i && mode_i != 2'd0) |=> ($stable(tc_o) && buf0_valid_o));

  // R5
  stall1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (buf1_valid_o && !buf1_ready_i && mode_i != 2'd0) |=> ($stable(tc_o) && buf1_valid_o));

  // R7
  eoq_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoq_flag_o) |-> (tc_o == '0));

  // R11
  err_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> !$past(buf0_valid_o || buf1_valid_o));

  // R12
  eoq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoq_flag_o && !flag_clr_i) |=> eoq_flag_o);

  // R12
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !flag_clr_i) |=> err_flag_o);

  // R13
  off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0) |=> (status_o == 2'd0 && tc_o == '0));

  // R2
  status_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o != 2'd3);
endmodule

bind cmdq_seq cmdq_seq_chk #(.CMD_W(CMD_W), .IDX_W(IDX_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .flag_clr_i   (flag_clr_i),
  .buf0_valid_o (buf0_valid_o),
  .buf0_ready_i (buf0_ready_i),
  .buf0_data_o  (buf0_data_o),
  .buf1_valid_o (buf1_valid_o),
  .buf1_ready_i (buf1_ready_i),
  .buf1_data_o  (buf1_data_o),
  .status_o     (status_o),
  .tc_o         (tc_o),
  .eoq_flag_o   (eoq_flag_o),
  .err_flag_o   (err_flag_o)
);

// File: tb/tb_cmdq_seq.sv
`timescale 1ns/1ps
module tb_cmdq_seq;
  localparam int CW = 32;
  localparam int DP = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [IW-1:0] wa = '0;
  logic [CW-1:0] wd = '0;
  logic [1:0]    mode = 2'd0;
  logic          arm = 1'b0, strm = 1'b0, trig = 1'b0, clr = 1'b0;
  logic          r0 = 1'b0, r1 = 1'b0;
  logic          v0, v1, fe, fp, fx;
  logic [CW-1:0] d0, d1;
  logic [1:0]    st;
  logic [IW-1:0] tc;

  cmdq_seq #(.CMD_W(CW), .DEPTH(DP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .load_we_i(we), .load_addr_i(wa), .load_data_i(wd),
    .mode_i(mode), .arm_i(arm), .stream_i(strm), .trig_i(trig), .flag_clr_i(clr),
    .buf0_valid_o(v0), .buf0_ready_i(r0), .buf0_data_o(d0),
    .buf1_valid_o(v1), .buf1_ready_i(r1), .buf1_data_o(d1),
    .status_o(st), .tc_o(tc), .eoq_flag_o(fe), .pause_flag_o(fp), .err_flag_o(fx)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit rdy_auto = 1'b1, fin = 1'b0;

  task automatic cmp(input longint act, input longint exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [CW-1:0] m_mem [DP];
  int m_st, m_tc, m_repi;
  bit m_repv, m_rel, m_trq, m_fe, m_fp, m_fx;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tc = 0; m_repi = 0; m_repv = 0; m_rel = 0; m_trq = 0;
      m_fe = 0; m_fp = 0; m_fx = 0;
    end else begin
      logic [CW-1:0] c;
      bit dn, edg;
      c   = m_mem[m_tc];
      dn  = (m_st == 2) && (c[5] || (c[6] ? r1 : r0));
      edg = trig && !m_trq;
      m_trq = trig;
      if (clr) begin m_fe = 0; m_fp = 0; m_fx = 0; end
      if (dn) begin
        if (c[0]) m_fe = 1;
        if (c[1]) m_fp = 1;
        if (c[5]) m_fx = 1;
      end
      if (mode == 0) begin
        m_st = 0; m_tc = 0; m_repv = 0; m_rel = 0;
      end else if (m_st == 0) begin
        if (arm) begin m_tc = 0; m_repv = 0; m_rel = 0; m_st = (mode == 3) ? 2 : 1; end
      end else if (m_st == 1) begin
        if (edg) begin
          m_st = 2;
          if (m_rel) begin m_tc = m_repi; m_rel = 0; end
        end
      end else if (dn) begin
        if (c[2] && !m_repv) begin m_repv = 1; m_repi = m_tc; end
        if (c[0]) begin
          m_tc = 0; m_repv = 0; m_rel = 0; m_st = (mode == 2) ? 1 : 0;
        end else begin
          m_tc = (m_tc + 1) % DP;
          if (c[1] && (mode == 1 || mode == 2)) begin
            m_rel = strm && m_repv; m_repv = 0; m_st = 1;
          end
        end
      end
      if (we) m_mem[wa] = wd;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      logic [CW-1:0] c;
      bit e0, e1;
      c  = m_mem[m_tc];
      e0 = (m_st == 2) && !c[5] && !c[6];
      e1 = (m_st == 2) && !c[5] && c[6];
      cmp(st, m_st, "R2 R3 R6 R7 R13 status");
      cmp(tc, m_tc, "R5 R9 R10 counter");
      cmp(v0, e0, "R4 R11 buf0_valid");
      cmp(v1, e1, "R4 R11 buf1_valid");
      if (e0) cmp(d0, c, "R4 buf0_data");
      if (e1) cmp(d1, c, "R4 buf1_data");
      cmp({fe, fp, fx}, {m_fe, m_fp, m_fx}, "R8 R11 R12 flags");
    end
  end

  // irregular buffer readiness plus watchdog
  always @(posedge clk) begin
    cyc++;
    #5;
    if (rdy_auto) begin r0 = (cyc % 3) != 0; r1 = cyc[0]; end
    else begin r0 = 1'b0; r1 = 1'b0; end
    if (cyc > 50000 && !fin) begin
      fin = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [CW-1:0] mk(bit eoq, bit pau, bit rep, bit ext, bit sel, bit cal, int pay);
    return {pay[23:0], cal, sel, ext, 2'b00, rep, pau, eoq};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic ld(input int a, input logic [CW-1:0] d);
    tick(1); we = 1'b1; wa = a[IW-1:0]; wd = d;
    tick(1); we = 1'b0;
  endtask

  task automatic pulse_arm(); tick(1); arm = 1'b1; tick(1); arm = 1'b0; endtask
  task automatic pulse_trig(); tick(1); trig = 1'b1; tick(1); trig = 1'b0; endtask

  task automatic go_off(); tick(1); mode = 2'd0; tick(2); endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    cmp(st, 0, "R1 status"); cmp(tc, 0, "R1 counter");
    cmp({v0, v1}, 0, "R1 valids"); cmp({fe, fp, fx}, 0, "R1 flags");

    // single scan with mid pause
    ld(0, mk(0,0,0,0,0,1,16'h1a1)); ld(1, mk(0,0,0,0,1,0,16'h1b2));
    ld(2, mk(0,1,0,0,0,0,16'h1c3)); ld(3, mk(0,0,0,0,1,1,16'h1d4));
    ld(4, mk(1,0,0,0,0,0,16'h1e5));
    for (int i = 5; i < DP; i++) ld(i, mk(0,0,0,0,i[0],0,i));
    pulse_trig(); tick(2);
    @(negedge clk); cmp(st, 0, "R3 trigger ignored in idle");
    mode = 2'd1; pulse_arm();
    @(negedge clk); cmp(st, 1, "R2 arm edge mode");
    tick(1); trig = 1'b1; tick(30);
    @(negedge clk); cmp(st, 1, "R6 parked at pause"); cmp(tc, 3, "R6 counter after pause");
    cmp(fp, 1, "R6 pause flag");
    trig = 1'b0; pulse_trig(); tick(30);
    @(negedge clk); cmp(st, 0, "R7 single ends idle"); cmp(tc, 0, "R7 counter wrap");
    cmp(fe, 1, "R7 eoq flag");
    tick(1); clr = 1'b1; tick(1); clr = 1'b0;
    @(negedge clk); cmp({fe, fp, fx}, 0, "R12 flags cleared");

    // continuous, pause+eoq together
    ld(2, mk(1,1,0,0,1,0,16'h2c3));
    mode = 2'd2; pulse_arm(); pulse_trig(); tick(30);
    @(negedge clk); cmp(st, 1, "R8 status follows eoq"); cmp(tc, 0, "R8 counter");
    cmp({fe, fp}, 2'b11, "R8 both flags");
    go_off();
    @(negedge clk); cmp(st, 0, "R13 off status"); cmp(tc, 0, "R13 off counter");

    // software mode with reserved command
    tick(1); clr = 1'b1; tick(1); clr = 1'b0;
    ld(1, mk(0,0,0,1,1,0,16'h3b2)); ld(2, mk(0,1,0,0,0,0,16'h3c3));
    mode = 2'd3; pulse_arm(); tick(30);
    @(negedge clk); cmp(st, 0, "R11 R6 soft run to end"); cmp(fx, 1, "R11 err flag");
    cmp(fp, 1, "R6 pause flag in soft mode");
    go_off();

    // streaming loop, two repeat-starts
    ld(0, mk(0,0,0,0,0,0,16'h40)); ld(1, mk(0,0,1,0,1,0,16'h41));
    ld(2, mk(0,0,1,0,0,1,16'h42)); ld(3, mk(0,1,0,0,1,0,16'h43));
    ld(4, mk(1,0,0,0,0,0,16'h44));
    strm = 1'b1; mode = 2'd1; pulse_arm(); pulse_trig(); tick(30);
    @(negedge clk); cmp(st, 1, "R9 parked"); cmp(tc, 4, "R9 counter past pause");
    tick(1); rdy_auto = 1'b0; trig = 1'b1; tick(1); trig = 1'b0;
    @(negedge clk); cmp(tc, 1, "R10 first repeat index reloaded"); cmp(st, 2, "R9 transferring");
    tick(4);
    @(negedge clk); cmp(tc, 1, "R5 stall holds counter"); cmp(v1, 1, "R5 valid held");
    rdy_auto = 1'b1; tick(30);
    @(negedge clk); cmp(tc, 4, "R9 loop parked again");
    go_off();
    strm = 1'b0;
    tick(3);

    fin = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule